// File: doc/BRIEF.md
# DMA Channel Stop Controller

This block decides, per channel of a linked-list DMA engine, how a running channel is brought to rest. The channel configuration (synchronization kind, buffering-disable flag, solid-fill and transparent-copy flags) sorts the channel into one of two stop styles.

- **Drain:** lets reading run on to the next request boundary, then empties the FIFO to the destination and signals completion with a one-cycle interrupt.
- **Abort:** halts both ports, waits for in-flight transactions to settle, then discards the FIFO contents.

A stop that begins while descriptors are being fetched always takes the abort path.

The bus engines, FIFO storage and descriptor parser sit outside the block. They report three things as inputs: reaching a request boundary, having no transaction outstanding, and the FIFO being empty. They obey the halt, flush and clear requests the block drives.

The controller is a Moore state machine with eight states:

- `ST_IDLE` moves to `ST_RUN` on a rising edge of the channel enable.
- `ST_RUN` moves on a stop trigger:
  - to `ST_DRN_BND` for a drain candidate in the data phase;
  - to `ST_ABT_WAIT` for any abort, including any trigger during the descriptor phase.
- `ST_DRN_BND` moves to `ST_DRN_FLUSH` on a boundary.
- `ST_DRN_FLUSH` moves to `ST_DRN_DONE` once the FIFO is empty and nothing is outstanding.
- `ST_DRN_DONE` moves to `ST_IDLE`.
- `ST_ABT_WAIT` moves to `ST_ABT_CLEAR` once nothing is outstanding.
- `ST_ABT_CLEAR` moves to `ST_ABT_DONE` once the FIFO is empty.
- `ST_ABT_DONE` moves to `ST_IDLE`.

Top module: `dma_stop_ctrl`

## Requirements
- R1: Sync codes are `cfg_sync` 2'b00 software, 2'b01 hardware source, 2'b10 hardware destination, 2'b11 handled as software. A channel is a drain candidate only when `cfg_sync`=2'b01, `cfg_buf_off`=0, `cfg_solid_fill`=0 and `cfg_transp_copy`=0. Every other channel is an abort candidate, and a channel never shows both flush and clear in one stop.
- R2: After reset all six outputs are low. A rising edge of `ch_enable` in idle starts the channel, and all outputs stay low while it runs.
- R3: For a drain candidate, a low `ch_enable` or a high `rd_err` is a stop trigger. `wr_err` and `misalign_err` have no effect, so the channel stays running with all outputs low.
- R4: A drain started in the data phase (`desc_phase`=0) keeps `rd_halt` low until `rd_boundary` is seen. From the next cycle it raises `rd_halt` and `fifo_flush`, with `wr_halt` low.
- R5: `fifo_flush` stays high until `fifo_empty` and `xfer_none` are both high. The next cycle shows `drain_end` and `chan_off` high for exactly one cycle, then the controller is idle.
- R6: For an abort candidate, a low `ch_enable`, `rd_err`, `wr_err` or `misalign_err` starts an abort. From the next cycle `rd_halt` and `wr_halt` are high.
- R7: Any stop trigger while `desc_phase`=1 takes the abort path, even for a drain candidate.
- R8: An abort holds both halts with `fifo_clear` low while `xfer_none` is low. It then raises `fifo_clear` until `fifo_empty` is high, and never raises `fifo_flush`.
- R9: An abort ends with one cycle of `chan_off` high and `drain_end` low, after which all outputs are low.
- R10: Triggers arriving during a stop sequence change nothing. After returning to idle, the channel restarts only on a fresh rising edge of `ch_enable`.
- R11: `fifo_flush` and `fifo_clear` are never high together, and `drain_end` is never high without `chan_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 2 | Synchronization kind code |
| cfg_buf_off | input | 1 | Buffering disabled |
| cfg_solid_fill | input | 1 | Solid-color fill mode |
| cfg_transp_copy | input | 1 | Transparent-copy mode |
| ch_enable | input | 1 | Channel enable |
| rd_err | input | 1 | Read-port transaction error |
| wr_err | input | 1 | Write-port transaction error |
| misalign_err | input | 1 | Address misalignment error |
| desc_phase | input | 1 | 1 = descriptor load, 0 = data load |
| rd_boundary | input | 1 | Read reached a request boundary |
| xfer_none | input | 1 | No transaction outstanding |
| fifo_empty | input | 1 | FIFO holds no data |
| rd_halt | output | 1 | Stop issuing reads |
| wr_halt | output | 1 | Stop issuing writes |
| fifo_flush | output | 1 | Deliver FIFO contents to destination |
| fifo_clear | output | 1 | Discard FIFO contents |
| drain_end | output | 1 | One-cycle drain-complete interrupt |
| chan_off | output | 1 | One-cycle pulse: channel is now disabled |

## Verification
The assertions assume the surrounding engines keep the configuration inputs steady from channel start until the stop completes. They also assume `xfer_none` and `fifo_empty` eventually rise once halts or flush requests are applied; otherwise the pulse checks are never reached. The stimulus resets the block before each scenario and changes configuration only while reset is held. It raises `xfer_none` and `fifo_empty` a few cycles after each stop begins, so every wait state is both held and left. Error inputs are given as single-cycle pulses, and extra triggers are injected inside the stop sequence to confirm they are ignored.

// File: rtl/dma_stop_pkg.sv
package dma_stop_pkg;

    localparam int SYNC_W = 2;

    typedef enum logic [SYNC_W-1:0] {
        SYNC_SW      = 2'b00,
        SYNC_HW_SRC  = 2'b01,
        SYNC_HW_DST  = 2'b10,
        SYNC_RSVD    = 2'b11
    } sync_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRN_BND,
        ST_DRN_FLUSH,
        ST_DRN_DONE,
        ST_ABT_WAIT,
        ST_ABT_CLEAR,
        ST_ABT_DONE
    } stop_state_e;

endpackage

// File: rtl/dma_stop_classify.sv
module dma_stop_classify
    import dma_stop_pkg::*;
(
    input  logic [SYNC_W-1:0] cfg_sync,
    input  logic              cfg_buf_off,
    input  logic              cfg_solid_fill,
    input  logic              cfg_transp_copy,
    output logic              is_drain
);
    sync_kind_e kind;

    always_comb begin
        kind = sync_kind_e'(cfg_sync);
        // Only buffered, source-paced, non-graphics channels may drain (R1)
        unique case (kind)
            SYNC_HW_SRC: is_drain = !cfg_buf_off && !cfg_solid_fill && !cfg_transp_copy;
            SYNC_SW,
            SYNC_HW_DST,
            SYNC_RSVD:   is_drain = 1'b0;
            default:     is_drain = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_stop_trigger.sv
module dma_stop_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_enable,
    input  logic rd_err,
    input  logic wr_err,
    input  logic misalign_err,
    output logic start,
    output logic drain_trig,
    output logic abort_trig
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= ch_enable;
    end

    always_comb begin
        start      = ch_enable && !en_q;
        drain_trig = !ch_enable || rd_err;
        abort_trig = drain_trig || wr_err || misalign_err;
    end
endmodule

// File: rtl/dma_stop_fsm.sv
module dma_stop_fsm
    import dma_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_drain,
    input  logic drain_trig,
    input  logic abort_trig,
    input  logic desc_phase,
    input  logic rd_boundary,
    input  logic xfer_none,
    input  logic fifo_empty,
    output logic rd_halt,
    output logic wr_halt,
    output logic fifo_flush,
    output logic fifo_clear,
    output logic drain_end,
    output logic chan_off
);
    stop_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_RUN;
            ST_RUN: begin
                if (is_drain) begin
                    if (drain_trig) nxt = desc_phase ? ST_ABT_WAIT : ST_DRN_BND;
                end else if (abort_trig) begin
                    nxt = ST_ABT_WAIT;
                end
            end
            ST_DRN_BND:   if (rd_boundary) nxt = ST_DRN_FLUSH;
            ST_DRN_FLUSH: if (fifo_empty && xfer_none) nxt = ST_DRN_DONE;
            ST_DRN_DONE:  nxt = ST_IDLE;
            ST_ABT_WAIT:  if (xfer_none) nxt = ST_ABT_CLEAR;
            ST_ABT_CLEAR: if (fifo_empty) nxt = ST_ABT_DONE;
            ST_ABT_DONE:  nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_halt    = 1'b0;
        wr_halt    = 1'b0;
        fifo_flush = 1'b0;
        fifo_clear = 1'b0;
        drain_end  = 1'b0;
        chan_off   = 1'b0;
        unique case (state)
            ST_IDLE, ST_RUN, ST_DRN_BND: ;
            ST_DRN_FLUSH: begin
                rd_halt    = 1'b1;
                fifo_flush = 1'b1;
            end
            ST_DRN_DONE: begin
                rd_halt   = 1'b1;
                drain_end = 1'b1;
                chan_off  = 1'b1;
            end
            ST_ABT_WAIT: begin
                rd_halt = 1'b1;
                wr_halt = 1'b1;
            end
            ST_ABT_CLEAR: begin
                rd_halt    = 1'b1;
                wr_halt    = 1'b1;
                fifo_clear = 1'b1;
            end
            ST_ABT_DONE: begin
                rd_halt  = 1'b1;
                wr_halt  = 1'b1;
                chan_off = 1'b1;
            end
            default: ;
        endcase
    end

    p_flush_clear_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_flush && fifo_clear));

    p_drain_end_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_end |-> chan_off);

    p_drain_end_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_end |=> !drain_end);

    p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_halt && !fifo_clear && !chan_off && !xfer_none) |=> (wr_halt && !fifo_clear && !chan_off));

    p_idle_after_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chan_off |=> (!rd_halt && !wr_halt && !chan_off));

    p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flush && !fifo_empty) |=> fifo_flush);
endmodule

// File: rtl/dma_stop_ctrl.sv
module dma_stop_ctrl
    import dma_stop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYNC_W-1:0] cfg_sync,
    input  logic              cfg_buf_off,
    input  logic              cfg_solid_fill,
    input  logic              cfg_transp_copy,
    input  logic              ch_enable,
    input  logic              rd_err,
    input  logic              wr_err,
    input  logic              misalign_err,
    input  logic              desc_phase,
    input  logic              rd_boundary,
    input  logic              xfer_none,
    input  logic              fifo_empty,
    output logic              rd_halt,
    output logic              wr_halt,
    output logic              fifo_flush,
    output logic              fifo_clear,
    output logic              drain_end,
    output logic              chan_off
);
    logic is_drain, start, drain_trig, abort_trig;

    dma_stop_classify u_class (
        .cfg_sync        (cfg_sync),
        .cfg_buf_off     (cfg_buf_off),
        .cfg_solid_fill  (cfg_solid_fill),
        .cfg_transp_copy (cfg_transp_copy),
        .is_drain        (is_drain)
    );

    dma_stop_trigger u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_enable    (ch_enable),
        .rd_err       (rd_err),
        .wr_err       (wr_err),
        .misalign_err (misalign_err),
        .start        (start),
        .drain_trig   (drain_trig),
        .abort_trig   (abort_trig)
    );

    dma_stop_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .is_drain    (is_drain),
        .drain_trig  (drain_trig),
        .abort_trig  (abort_trig),
        .desc_phase  (desc_phase),
        .rd_boundary (rd_boundary),
        .xfer_none   (xfer_none),
        .fifo_empty  (fifo_empty),
        .rd_halt     (rd_halt),
        .wr_halt     (wr_halt),
        .fifo_flush  (fifo_flush),
        .fifo_clear  (fifo_clear),
        .drain_end   (drain_end),
        .chan_off    (chan_off)
    );

    // A drain-style channel never gets write halt before its flush (R4)
    p_no_wr_halt_on_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> !wr_halt);
endmodule

// File: tb/dma_stop_ctrl_test.sv
module dma_stop_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_sync = 2'b00;
    logic       cfg_buf_off = 1'b0, cfg_solid_fill = 1'b0, cfg_transp_copy = 1'b0;
    logic       ch_enable = 1'b0, rd_err = 1'b0, wr_err = 1'b0, misalign_err = 1'b0;
    logic       desc_phase = 1'b0, rd_boundary = 1'b0, xfer_none = 1'b0, fifo_empty = 1'b0;
    logic       rd_halt, wr_halt, fifo_flush, fifo_clear, drain_end, chan_off;

    int n_tests = 0;
    int n_fail  = 0;
    int m_st    = 0;
    bit m_en_q  = 1'b0;
    bit saw_flush, saw_clear, saw_dend;

    always #10 clk = ~clk;

    dma_stop_ctrl uut (.*);

    // Behavioural reference: 0 idle,1 run,2 wait boundary,3 flush,4 drain done,
    // 5 abort wait,6 abort clear,7 abort done
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st   = 0;
            m_en_q = 1'b0;
        end else begin
            bit dr, dt, at;
            dr = (cfg_sync == 2'b01) && !cfg_buf_off && !cfg_solid_fill && !cfg_transp_copy;
            dt = !ch_enable || rd_err;
            at = dt || wr_err || misalign_err;
            case (m_st)
                0: if (ch_enable && !m_en_q) m_st = 1;
                1: if (dr ? dt : at) m_st = (dr && !desc_phase) ? 2 : 5;
                2: if (rd_boundary) m_st = 3;
                3: if (fifo_empty && xfer_none) m_st = 4;
                5: if (xfer_none) m_st = 6;
                6: if (fifo_empty) m_st = 7;
                default: m_st = 0;
            endcase
            m_en_q = ch_enable;
        end
    end

    task automatic check(input bit act, input bit exp, input string req, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (model state %0d)", req, what, act, exp, m_st);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check(rd_halt,    m_st inside {3,4,5,6,7}, "R4/R6", "rd_halt");
        check(wr_halt,    m_st inside {5,6,7},     "R6",    "wr_halt");
        check(fifo_flush, m_st == 3,               "R5",    "fifo_flush");
        check(fifo_clear, m_st == 6,               "R8",    "fifo_clear");
        check(drain_end,  m_st == 4,               "R5",    "drain_end");
        check(chan_off,   m_st inside {4,7},       "R9",    "chan_off");
        if (fifo_flush) saw_flush = 1'b1;
        if (fifo_clear) saw_clear = 1'b1;
        if (drain_end)  saw_dend  = 1'b1;
    endtask

    // kind: 0 enable low, 1 rd_err, 2 wr_err, 3 misalign; expect: 0 none, 1 drain, 2 abort
    task automatic scenario(input logic [1:0] sync, input bit bo, input bit fill, input bit tr,
                            input bit desc, input int kind, input int expect_path, input string req);
        rst_n = 1'b0;
        cfg_sync = sync; cfg_buf_off = bo; cfg_solid_fill = fill; cfg_transp_copy = tr;
        desc_phase = desc; ch_enable = 1'b0; rd_err = 1'b0; wr_err = 1'b0; misalign_err = 1'b0;
        rd_boundary = 1'b0; xfer_none = 1'b0; fifo_empty = 1'b0;
        tick();
        rst_n = 1'b1;
        saw_flush = 1'b0; saw_clear = 1'b0; saw_dend = 1'b0;
        tick();
        check(rd_halt | wr_halt | chan_off, 1'b0, "R2", "reset outputs");
        ch_enable = 1'b1;
        tick(); tick();
        case (kind)
            0: ch_enable = 1'b0;
            1: rd_err = 1'b1;
            2: wr_err = 1'b1;
            default: misalign_err = 1'b1;
        endcase
        tick();
        rd_err = 1'b0; wr_err = 1'b0; misalign_err = 1'b0;
        tick();
        // R10: extra triggers inside the stop sequence
        wr_err = 1'b1; misalign_err = 1'b1;
        tick();
        wr_err = 1'b0; misalign_err = 1'b0;
        tick();
        rd_boundary = 1'b1;
        tick();
        rd_boundary = 1'b0;
        tick(); tick();
        xfer_none = 1'b1;
        tick(); tick();
        fifo_empty = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        case (expect_path)
            1: begin
                check(saw_flush, 1'b1, req, "drain path flushed");
                check(saw_dend,  1'b1, req, "drain path end pulse");
                check(saw_clear, 1'b0, req, "drain path no clear");
            end
            2: begin
                check(saw_clear, 1'b1, req, "abort path cleared");
                check(saw_flush, 1'b0, req, "abort path no flush");
                check(saw_dend,  1'b0, req, "abort path no drain_end");
            end
            default: begin
                check(saw_flush | saw_clear | rd_halt, 1'b0, req, "ignored trigger, still running");
            end
        endcase
        // R10: enable still high after stop must not restart
        for (int i = 0; i < 3; i++) tick();
        check(rd_halt | chan_off, 1'b0, "R10", "no restart without new enable edge");
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R3 R4 R5: drain candidate, data phase, read error trigger
        scenario(2'b01, 0, 0, 0, 0, 1, 1, "R3");
        // R4: enable-low trigger also drains
        scenario(2'b01, 0, 0, 0, 0, 0, 1, "R4");
        // R3: write error and misalignment are ignored by a drain candidate
        scenario(2'b01, 0, 0, 0, 0, 2, 0, "R3");
        scenario(2'b01, 0, 0, 0, 0, 3, 0, "R3");
        // R7: descriptor phase turns a drain into an abort
        scenario(2'b01, 0, 0, 0, 1, 1, 2, "R7");
        scenario(2'b01, 0, 0, 0, 1, 0, 2, "R7");
        // R1 R6 R8 R9: abort candidates of each kind
        scenario(2'b00, 0, 0, 0, 0, 2, 2, "R6");
        scenario(2'b10, 0, 0, 0, 0, 3, 2, "R8");
        scenario(2'b01, 1, 0, 0, 0, 1, 2, "R1");
        scenario(2'b01, 0, 1, 0, 0, 0, 2, "R1");
        scenario(2'b01, 0, 0, 1, 0, 3, 2, "R9");
        scenario(2'b11, 0, 0, 0, 0, 1, 2, "R1");
        // R11 is checked on every cycle via the exclusive output comparison
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule